// File: doc/BRIEF.md
# CRC32 Memory Scanner

This block computes a CRC-32 checksum over a contiguous stretch of word-wide memory. It is controlled through a small register port. Software loads a start word index, a word count and a seed. It then writes the start bit. The engine walks the region with a read master that keeps one request in flight and folds each returned 32-bit word into the running checksum in one cycle. When the walk completes, a status flag rises. A read that comes back with an error ends the walk early and raises two other flags.

The walker is a three-state machine. `ST_IDLE` waits for a start command. A start with a nonzero count loads the internal address and remaining-count copies and moves to `ST_ISSUE`. A start with a zero count completes at once and stays in `ST_IDLE`. `ST_ISSUE` holds the read request until the memory accepts it, then moves to `ST_AWAIT`. `ST_AWAIT` waits for the response. A good response that is not the last word returns to `ST_ISSUE` for the next address. The last good response returns to `ST_IDLE` with completion. An error response returns to `ST_IDLE` with failure.

The checksum register holds the raw, uncomplemented value. The conventional CRC-32 result is its bitwise inverse when the seed was all ones.

Top module: `crc_scan_engine`

## Requirements
- R1: After reset, every readable register reads zero and no memory request is raised. Register offsets: 0x00 control (bit 0 = start, reads zero), 0x04 status (bit 0 = DONE, bit 1 = FAIL, bit 2 = BERR), 0x08 start word index, 0x0C word count, 0x10 checksum.
- R2: Each good response word updates the checksum with the reflected polynomial 0xEDB88320. The word's bits are consumed least significant first, so byte 0 goes first. The register keeps the raw value with no final inversion.
- R3: Requests go to word index A, A+1, … for N words, with at most one outstanding request. A request holds its valid and address stable until it is accepted.
- R4: DONE is set in the cycle after the last good response is taken.
- R5: An error response ends the run with no further requests. It sets FAIL and BERR and does not set DONE. The checksum keeps the value folded from the words read before the error.
- R6: Writing 1 to a status bit clears that bit. Writing 0 to a bit leaves it unchanged.
- R7: A start command while a run is in progress has no effect.
- R8: A start with a word count of zero sets DONE on the next cycle, issues no request and leaves the checksum unchanged.
- R9: Writes to the start index, word count and checksum registers are ignored while a run is in progress.
- R10: When a status flag is set by the engine and cleared by software in the same cycle, the flag ends up set.
- R11: A run leaves the start index and word count registers at their programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Word index of the read |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| mem_rsp_err | input | 1 | Read response carries an error |

## Verification
Completion of the last word and a software write-1-to-clear of the DONE flag can land on the same clock edge. The bench provokes this by counting the responses its memory model returns. It drives the status clear in exactly the cycle that presents the final good response, with DONE already set from an earlier run. The outcome is judged by reading DONE back as set and the checksum as the value expected for the region. A stray start, a checksum write and an address write are also issued while the walker is busy. Their effect is judged by the request count, the final checksum and the register readback.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;
    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_STATUS = 5'h04;
    localparam logic [4:0] OFS_BASE   = 5'h08;
    localparam logic [4:0] OFS_COUNT  = 5'h0C;
    localparam logic [4:0] OFS_SUM    = 5'h10;

    localparam int BIT_DONE = 0;
    localparam int BIT_FAIL = 1;
    localparam int BIT_BERR = 2;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_AWAIT = 2'd2
    } walk_state_e;
endpackage

// File: rtl/crc_word_fold.sv
module crc_word_fold
    import crc_scan_pkg::*;
#(
    parameter int          WORD_W = 32,
    parameter logic [31:0] POLY   = CRC_POLY_REFL
) (
    input  logic [31:0]       crc_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [31:0]       crc_out
);
    logic [31:0] stage [0:WORD_W];

    assign stage[0] = crc_in ^ 32'(word_in);

    // One shift step per data bit, least significant bit first.
    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
    end

    assign crc_out = stage[WORD_W];
endmodule

// File: rtl/crc_scan_walker.sv
module crc_scan_walker
    import crc_scan_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic [ADDR_W-1:0] base_idx,
    input  logic [LEN_W-1:0]  word_cnt,
    input  logic [31:0]       crc_cur,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              crc_we,
    output logic [31:0]       crc_next,
    output logic              done_set,
    output logic              fail_set
);
    walk_state_e       state_q;
    logic [ADDR_W-1:0] cur_idx_q;
    logic [LEN_W-1:0]  left_q;
    logic              last_word;
    logic              rsp_good;
    logic              rsp_bad;

    assign last_word = (left_q == LEN_W'(1));
    assign rsp_good  = (state_q == ST_AWAIT) && mem_rsp_valid && !mem_rsp_err;
    assign rsp_bad   = (state_q == ST_AWAIT) && mem_rsp_valid && mem_rsp_err;

    crc_word_fold #(.WORD_W(32), .POLY(CRC_POLY_REFL)) u_fold (
        .crc_in  (crc_cur),
        .word_in (mem_rsp_data),
        .crc_out (crc_next)
    );

    // State register with address and remaining-count copies.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_idx_q <= '0;
            left_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_cmd) begin
                        cur_idx_q <= base_idx;
                        left_q    <= word_cnt;
                        if (word_cnt != '0) state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (mem_req_ready) state_q <= ST_AWAIT;
                end
                ST_AWAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err || last_word) begin
                            state_q <= ST_IDLE;
                            left_q  <= '0;
                        end else begin
                            state_q   <= ST_ISSUE;
                            left_q    <= left_q - LEN_W'(1);
                            cur_idx_q <= cur_idx_q + ADDR_W'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy          = (state_q != ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = cur_idx_q;
        crc_we        = rsp_good;
        fail_set      = rsp_bad;
        done_set      = (rsp_good && last_word) ||
                        ((state_q == ST_IDLE) && start_cmd && (word_cnt == '0));
    end

    // R3: a pending request stays put until accepted
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R3: each follow-on request targets the next word
    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) && $past(busy) |-> mem_req_addr == $past(mem_req_addr) + ADDR_W'(1));

    // R5: completion and failure never coincide
    p_done_xor_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_set && fail_set));

    // R5: no request right after an error response
    p_stop_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fail_set |=> !mem_req_valid && !busy);
endmodule

// File: rtl/crc_scan_engine.sv
module crc_scan_engine
    import crc_scan_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err
);
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  count_q;
    logic [31:0]       sum_q;
    logic              done_q, fail_q, berr_q;

    logic        busy, crc_we, done_set, fail_set;
    logic [31:0] crc_next;
    logic        start_cmd, wr_status, cfg_open;

    assign start_cmd = reg_wr_en && (reg_addr == OFS_CTRL) && reg_wdata[0];
    assign wr_status = reg_wr_en && (reg_addr == OFS_STATUS);
    assign cfg_open  = reg_wr_en && !busy;

    crc_scan_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_cmd     (start_cmd),
        .base_idx      (base_q),
        .word_cnt      (count_q),
        .crc_cur       (sum_q),
        .busy          (busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err),
        .crc_we        (crc_we),
        .crc_next      (crc_next),
        .done_set      (done_set),
        .fail_set      (fail_set)
    );

    // Configuration and checksum registers; frozen while a run is active.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
            sum_q   <= '0;
        end else begin
            if (cfg_open && reg_addr == OFS_BASE)  base_q  <= reg_wdata[ADDR_W-1:0];
            if (cfg_open && reg_addr == OFS_COUNT) count_q <= reg_wdata[LEN_W-1:0];
            if (crc_we)                            sum_q   <= crc_next;
            else if (cfg_open && reg_addr == OFS_SUM) sum_q <= reg_wdata;
        end
    end

    // Status flags: engine set takes priority over a write-1 clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            berr_q <= 1'b0;
        end else begin
            done_q <= done_set || (done_q && !(wr_status && reg_wdata[BIT_DONE]));
            fail_q <= fail_set || (fail_q && !(wr_status && reg_wdata[BIT_FAIL]));
            berr_q <= fail_set || (berr_q && !(wr_status && reg_wdata[BIT_BERR]));
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STATUS: reg_rdata = {29'd0, berr_q, fail_q, done_q};
            OFS_BASE:   reg_rdata = 32'(base_q);
            OFS_COUNT:  reg_rdata = 32'(count_q);
            OFS_SUM:    reg_rdata = sum_q;
            default:    reg_rdata = 32'd0;
        endcase
    end

    // R5: an error response leaves FAIL and BERR raised
    p_err_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid && mem_rsp_err && busy && !mem_req_valid |=> fail_q && berr_q);

    // R8: zero-length start completes on the next cycle
    p_len0_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd && !busy && count_q == '0 |=> done_q && !busy);

    // R9: checksum moves only through the fold while running
    p_sum_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !crc_we |=> $stable(sum_q));

    // R10: an engine set survives a same-cycle clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> done_q);
endmodule

// File: tb/test_crc_scan_engine.sv
`timescale 1ns/1ps
module test_crc_scan_engine;
    localparam int ADDR_W = 30;
    localparam int LEN_W  = 16;
    localparam logic [31:0] POLY = 32'hEDB88320;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [4:0]        reg_addr = 5'd0;
    logic [31:0]       reg_wdata = 32'd0;
    logic [31:0]       reg_rdata;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [31:0]       mem_rsp_data = 32'd0;
    logic              mem_rsp_err = 1'b0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int req_count = 0;
    int rsp_count = 0;
    int err_idx = -1;
    bit slow = 1'b0;
    logic [31:0] mem [0:63];
    int req_log [0:63];

    always #2 clk = ~clk;

    crc_scan_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_crc_scan_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
    );

    // Memory model: response one cycle after acceptance.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_rsp_valid) rsp_count <= rsp_count + 1;
        if (mem_req_valid && mem_req_ready) begin
            req_log[req_count[5:0]] <= int'(mem_req_addr);
            req_count     <= req_count + 1;
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_req_addr[5:0]];
            mem_rsp_err   <= (int'(mem_req_addr) == err_idx);
        end else begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
        end
    end

    always @(negedge clk) mem_req_ready <= slow ? ~mem_req_ready : 1'b1;

    always @(posedge clk) begin
        if (cycles > 50000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] ref_crc(input logic [31:0] seed, input int first, input int n);
        logic [31:0] c = seed;
        for (int w = 0; w < n; w++) begin
            for (int b = 0; b < 4; b++) begin
                c = c ^ {24'd0, mem[first + w][8*b +: 8]};
                for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
            end
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_end();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            reg_read(5'h04, s);
            if (s[0] || s[1]) break;
        end
    endtask

    task automatic run(input int base, input int n, input logic [31:0] seed);
        reg_write(5'h08, base);
        reg_write(5'h0C, n);
        reg_write(5'h10, seed);
        reg_write(5'h04, 32'h7);
        req_count = 0; rsp_count = 0;
        reg_write(5'h00, 32'h1);
        wait_end();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        reg_read(5'h04, v); check("R1 status", v, 0);
        reg_read(5'h10, v); check("R1 sum", v, 0);
        reg_read(5'h08, v); check("R1 base", v, 0);
        reg_read(5'h0C, v); check("R1 count", v, 0);
        reg_read(5'h00, v); check("R1 ctrl", v, 0);
        check("R1 req_valid", {31'd0, mem_req_valid}, 0);
    endtask

    task automatic t_known_zero();
        logic [31:0] v;
        mem[0] = 32'd0;
        run(0, 1, 32'hFFFFFFFF);
        reg_read(5'h10, v);
        check("R2 raw zero word", v, 32'hDEBB20E3);
        check("R2 complemented", ~v, 32'h2144DF1C);
        reg_read(5'h04, v); check("R4 done", v, 32'h1);
    endtask

    task automatic t_multi_stall();
        logic [31:0] v;
        slow = 1'b1;
        run(5, 8, 32'hFFFFFFFF);
        slow = 1'b0;
        reg_read(5'h10, v); check("R2 eight words", v, ref_crc(32'hFFFFFFFF, 5, 8));
        check("R3 request count", req_count, 8);
        for (int i = 0; i < 8; i++) check("R3 address order", req_log[i], 5 + i);
        reg_read(5'h04, v); check("R4 done after stall run", v, 32'h1);
        reg_read(5'h08, v); check("R11 base kept", v, 5);
        reg_read(5'h0C, v); check("R11 count kept", v, 8);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        reg_write(5'h04, 32'h0); reg_read(5'h04, v); check("R6 write zero keeps", v, 32'h1);
        reg_write(5'h04, 32'h6); reg_read(5'h04, v); check("R6 other bits keep done", v, 32'h1);
        reg_write(5'h04, 32'h1); reg_read(5'h04, v); check("R6 clear done", v, 32'h0);
    endtask

    task automatic t_error();
        logic [31:0] v;
        err_idx = 20;
        run(18, 6, 32'hFFFFFFFF);
        repeat (4) @(negedge clk);
        reg_read(5'h04, v); check("R5 fail+berr no done", v, 32'h6);
        check("R5 requests stop", req_count, 3);
        reg_read(5'h10, v); check("R5 partial sum", v, ref_crc(32'hFFFFFFFF, 18, 2));
        reg_write(5'h04, 32'h4); reg_read(5'h04, v); check("R6 clear berr only", v, 32'h2);
        err_idx = -1;
    endtask

    task automatic t_busy_writes();
        logic [31:0] v;
        slow = 1'b1;
        reg_write(5'h08, 0);
        reg_write(5'h0C, 10);
        reg_write(5'h10, 32'hFFFFFFFF);
        reg_write(5'h04, 32'h7);
        req_count = 0; rsp_count = 0;
        reg_write(5'h00, 32'h1);
        repeat (3) @(negedge clk);
        reg_write(5'h00, 32'h1);
        reg_write(5'h10, 32'h12345678);
        reg_write(5'h08, 40);
        reg_write(5'h0C, 3);
        wait_end();
        slow = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 no restart", req_count, 10);
        reg_read(5'h10, v); check("R9 sum write ignored", v, ref_crc(32'hFFFFFFFF, 0, 10));
        reg_read(5'h08, v); check("R9 base write ignored", v, 0);
        reg_read(5'h0C, v); check("R9 count write ignored", v, 10);
    endtask

    task automatic t_len0();
        logic [31:0] v;
        reg_write(5'h10, 32'hA5A5C3C3);
        reg_write(5'h0C, 0);
        reg_write(5'h04, 32'h7);
        req_count = 0;
        reg_write(5'h00, 32'h1);
        reg_read(5'h04, v); check("R8 immediate done", v, 32'h1);
        reg_read(5'h10, v); check("R8 sum unchanged", v, 32'hA5A5C3C3);
        check("R8 no request", req_count, 0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        reg_write(5'h08, 2);
        reg_write(5'h0C, 3);
        reg_write(5'h10, 32'hFFFFFFFF);
        req_count = 0; rsp_count = 0;
        reg_write(5'h00, 32'h1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_rsp_valid && rsp_count == 2) break;
        end
        reg_wr_en = 1'b1; reg_addr = 5'h04; reg_wdata = 32'h1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_read(5'h04, v); check("R10 set beats clear", v, 32'h1);
        reg_read(5'h10, v); check("R10 sum intact", v, ref_crc(32'hFFFFFFFF, 2, 3));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = (i * 32'h9E3779B9) ^ (i << 7) ^ 32'h0F1E2D3C;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_known_zero();
        t_multi_stall();
        t_w1c();
        t_error();
        t_busy_writes();
        t_len0();
        t_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule